// File: doc/BRIEF.md
# Interval Counter with Sticky Match Flag

This block is a memory-mapped interval counter seen by software as a small window of 32-bit words. Each pulse on the tick enable, one per 500 ns time unit, adds one to a count field that starts at bit 9 of the readback word. Software programs a limit. When the next count value equals a non-zero limit, the count returns to zero on that same tick, a sticky match flag is set, and a level interrupt is raised. A limit of zero makes the counter free-running: it then never matches and never interrupts.

Two write paths load the limit. The primary one restarts the interval and clears any pending interrupt. The secondary one changes the limit and leaves the count and the flag as they are. A read of the primary limit word is the interrupt acknowledge. It returns the limit with the flag in bit 31 and then clears the flag.

A three-state controller holds the match status. The states are `ST_FREE` (limit zero, flag clear), `ST_ARMED` (limit non-zero, flag clear) and `ST_HIT` (flag set, interrupt high). Its transitions are:

- `limit_load`: a primary limit write enters `ST_ARMED` or `ST_FREE`, according to the new limit.
- `match`: any state goes to `ST_HIT`.
- `ack`: a primary limit read leaves `ST_HIT` for `ST_ARMED` or `ST_FREE`.
- `retarget`: `ST_FREE` and `ST_ARMED` follow the limit after a secondary write.
- `hold`: every other case keeps the current state.

Top module: `icnt_timer`

## Requirements
- R1: After reset, the count, the limit and the flag are zero. `irq` is low, and reads of offsets 0 and 1 return 0.
- R2: Each cycle with `tick` high adds one unit of bit 9 to the count. Bits 8..0 of every readback are zero, and without `tick` the count holds.
- R3: A write to word offset 0 stores `wdata & 32'h7FFF_FE00` as the limit, sets the count to zero and clears the flag and `irq` from the next cycle.
- R4: With a non-zero limit of L units, the L-th tick after the count was zero returns the count to zero, sets the flag and raises `irq` in the next cycle.
- R5: The flag and `irq` stay high through further ticks and matches until a read or a write of offset 0.
- R6: Offset 0 reads as `{flag, limit[30:9], 9'b0}`. A cycle with `rd_en` high at offset 0 clears the flag and `irq` for the next cycle, unless a match occurs in that same cycle, which keeps them set.
- R7: While the limit is zero, the count runs without matching and `irq` stays low.
- R8: A write to word offset 2 replaces the limit masked with `32'h7FFF_FE00` and leaves the count and the flag unchanged. The new limit takes effect from the next cycle.
- R9: Offset 1 reads as `{flag, count[30:9], 9'b0}`, and writes to it have no effect. Offsets 2 to 7 read as zero, and writes to offsets 3 to 7 have no effect.
- R10: When a write to offset 0 and a tick occur in the same cycle, the write wins and the count is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-unit enable, one pulse per 500 ns |
| addr | input | 3 | Word offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect: acknowledge at offset 0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational readback of the addressed word |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The assertions check these properties on every cycle:

- A match always raises `irq` in the next cycle.
- A primary limit write clears the count and `irq`.
- The flag is sticky and is released only by an offset-0 access.
- An acknowledge without a concurrent match drops `irq`.
- A zero limit can never raise `irq`.
- The count changes only on a tick or a primary limit write.

Only the bench's scenarios can show the full interval length for a given limit, the exact readback words with their masking, the ignored offsets, and the same-cycle races between a tick and a bus access. These are compared against a requirement-level model under directed and seeded random traffic.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } icnt_state_e;

    localparam int unsigned OFF_LIMIT      = 0;
    localparam int unsigned OFF_COUNT      = 1;
    localparam int unsigned OFF_LIMIT_KEEP = 2;

endpackage

// File: rtl/icnt_decode.sv
module icnt_decode #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FRAC_W = 9,
    parameter int unsigned CW     = DATA_W - 1 - FRAC_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              flag,
    input  logic [CW-1:0]     cnt,
    input  logic [CW-1:0]     lim,
    output logic              wr_lim,
    output logic              wr_keep,
    output logic              rd_lim,
    output logic [DATA_W-1:0] rdata
);
    import icnt_pkg::*;

    logic sel_lim;
    logic sel_cnt;
    logic sel_keep;

    assign sel_lim  = (addr == ADDR_W'(OFF_LIMIT));
    assign sel_cnt  = (addr == ADDR_W'(OFF_COUNT));
    assign sel_keep = (addr == ADDR_W'(OFF_LIMIT_KEEP));

    assign wr_lim  = wr_en & sel_lim;
    assign wr_keep = wr_en & sel_keep;
    assign rd_lim  = rd_en & sel_lim;

    always_comb begin
        rdata = '0;
        if (sel_lim) begin
            rdata = {flag, lim, {FRAC_W{1'b0}}};
        end else if (sel_cnt) begin
            rdata = {flag, cnt, {FRAC_W{1'b0}}};
        end
    end

endmodule

// File: rtl/icnt_count.sv
module icnt_count #(
    parameter int unsigned CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lim,
    output logic          lim_nz_next,
    output logic          match
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc     = cnt_q + CW'(1);
    assign match       = tick && !clr && (lim_q != '0) && (cnt_inc == lim_q);
    assign lim_nz_next = ld ? (ld_val != '0) : (lim_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= match ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (ld) begin
            lim_q <= ld_val;
        end
    end

    assign cnt = cnt_q;
    assign lim = lim_q;

endmodule

// File: rtl/icnt_fsm.sv
module icnt_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic limit_load,
    input  logic match,
    input  logic ack,
    input  logic lim_nz_next,
    output logic flag,
    output logic irq
);
    import icnt_pkg::*;

    icnt_state_e state_q;
    icnt_state_e state_d;
    icnt_state_e idle_d;

    assign idle_d = lim_nz_next ? ST_ARMED : ST_FREE;

    always_comb begin
        state_d = state_q;
        if (limit_load) begin
            state_d = idle_d;
        end else if (match) begin
            state_d = ST_HIT;
        end else begin
            unique case (state_q)
                ST_HIT:   state_d = ack ? idle_d : ST_HIT;
                ST_FREE:  state_d = idle_d;
                ST_ARMED: state_d = idle_d;
                default:  state_d = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag = (state_q == ST_HIT);
        irq  = (state_q == ST_HIT);
    end

endmodule

// File: rtl/icnt_timer.sv
module icnt_timer #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FRAC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int unsigned CW = DATA_W - 1 - FRAC_W;

    logic          wr_lim;
    logic          wr_keep;
    logic          rd_lim;
    logic          flag;
    logic          s_match;
    logic          lim_nz_next;
    logic [CW-1:0] s_cnt;
    logic [CW-1:0] s_lim;
    logic          unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1], wdata[FRAC_W-1:0]};

    icnt_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .FRAC_W(FRAC_W),
        .CW    (CW)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .flag   (flag),
        .cnt    (s_cnt),
        .lim    (s_lim),
        .wr_lim (wr_lim),
        .wr_keep(wr_keep),
        .rd_lim (rd_lim),
        .rdata  (rdata)
    );

    icnt_count #(
        .CW(CW)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clr        (wr_lim),
        .ld         (wr_lim | wr_keep),
        .ld_val     (wdata[DATA_W-2:FRAC_W]),
        .cnt        (s_cnt),
        .lim        (s_lim),
        .lim_nz_next(lim_nz_next),
        .match      (s_match)
    );

    icnt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .limit_load (wr_lim),
        .match      (s_match),
        .ack        (rd_lim),
        .lim_nz_next(lim_nz_next),
        .flag       (flag),
        .irq        (irq)
    );

endmodule

// File: rtl/icnt_timer_chk.sv
module icnt_timer_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CW     = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              irq,
    input logic              s_match,
    input logic [CW-1:0]     s_cnt,
    input logic [CW-1:0]     s_lim
);
    a_r4_match_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        s_match |=> irq);

    a_r3_limit_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (!irq && s_cnt == '0));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == '0) && !(wr_en && addr == '0)) |=> irq);

    a_r6_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0 && !wr_en && !s_match) |=> !irq);

    a_r7_free_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lim == '0 && !irq) |=> !irq);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_en && addr == '0)) |=> $stable(s_cnt));

    a_r8_keep_write_counts_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2) && tick && !s_match) |=> (s_cnt == CW'($past(s_cnt) + CW'(1))));

endmodule

bind icnt_timer icnt_timer_chk #(
    .ADDR_W(ADDR_W),
    .CW    (CW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .irq    (irq),
    .s_match(s_match),
    .s_cnt  (s_cnt),
    .s_lim  (s_lim)
);

// File: tb/tb_icnt_timer.sv
module tb_icnt_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [2:0]  addr;
    logic        wr_en;
    logic        rd_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    icnt_timer dut (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .addr (addr),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [21:0] m_cnt;
    logic [21:0] m_lim;
    logic        m_flag;

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        if (a == 3'd0) return {m_flag, m_lim, 9'b0};
        if (a == 3'd1) return {m_flag, m_cnt, 9'b0};
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic r,
                       input logic [2:0] a, input logic [31:0] d, input string tag);
        logic [21:0] inc;
        logic        mt;
        @(negedge clk);
        tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        check(tag, rdata, exp_rd(a));
        check(tag, {31'b0, irq}, {31'b0, m_flag});
        @(posedge clk);
        inc = m_cnt + 22'd1;
        mt  = t && !(w && a == 3'd0) && (m_lim != 22'd0) && (inc == m_lim);
        if (w && a == 3'd0) m_cnt = 22'd0;
        else if (t) m_cnt = mt ? 22'd0 : inc;
        if (w && a == 3'd0) m_flag = 1'b0;
        else if (mt) m_flag = 1'b1;
        else if (r && a == 3'd0) m_flag = 1'b0;
        if (w && (a == 3'd0 || a == 3'd2)) m_lim = d[30:9];
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5A17));
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 3'd0; wdata = 32'h0;
        m_cnt = 22'd0; m_lim = 22'd0; m_flag = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc(0, 0, 0, 3'd0, 32'h0, "R1");
        cyc(0, 0, 0, 3'd1, 32'h0, "R1");

        // R2: ticks advance the count, idle cycles hold it
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 3'd1, 32'h0, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3'd1, 32'h0, "R2");

        // R3: limit write with masked bits, count reset
        cyc(0, 1, 0, 3'd0, 32'h8000_0A37, "R3");
        cyc(0, 0, 0, 3'd0, 32'h0, "R3");
        cyc(0, 0, 0, 3'd1, 32'h0, "R3");

        // R4: five ticks reach limit 5
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 3'd1, 32'h0, "R4");
        cyc(0, 0, 0, 3'd1, 32'h0, "R4");

        // R5: flag sticky through further ticks and a second match
        for (int i = 0; i < 7; i++) cyc(1, 0, 0, 3'd1, 32'h0, "R5");

        // R9: ignored writes and zero-reading offsets
        cyc(0, 1, 0, 3'd1, 32'hFFFF_FFFF, "R9");
        cyc(0, 1, 0, 3'd6, 32'hFFFF_FFFF, "R9");
        for (int a = 1; a < 8; a++) cyc(0, 0, 0, 3'(a), 32'h0, "R9");

        // R6: read acknowledge returns flag then clears it
        cyc(0, 0, 1, 3'd0, 32'h0, "R6");
        cyc(0, 0, 0, 3'd0, 32'h0, "R6");

        // R8: secondary limit write keeps the count
        cyc(0, 1, 0, 3'd0, 32'h0000_0A00, "R8");
        cyc(1, 0, 0, 3'd1, 32'h0, "R8");
        cyc(1, 0, 0, 3'd1, 32'h0, "R8");
        cyc(0, 1, 0, 3'd2, 32'h0000_0600, "R8");
        cyc(1, 0, 0, 3'd1, 32'h0, "R8");
        cyc(0, 0, 0, 3'd1, 32'h0, "R8");

        // R6: acknowledge in the same cycle as a match keeps the flag
        cyc(0, 1, 0, 3'd0, 32'h0000_0400, "R6");
        cyc(1, 0, 0, 3'd1, 32'h0, "R6");
        cyc(1, 0, 1, 3'd0, 32'h0, "R6");
        cyc(0, 0, 0, 3'd0, 32'h0, "R6");

        // R10: primary write wins over a tick
        cyc(1, 0, 0, 3'd1, 32'h0, "R10");
        cyc(1, 1, 0, 3'd0, 32'h0000_1000, "R10");
        cyc(0, 0, 0, 3'd1, 32'h0, "R10");

        // R7: free-run never interrupts
        cyc(0, 1, 0, 3'd0, 32'h0000_01FF, "R7");
        for (int i = 0; i < 300; i++) cyc(1, 0, 0, 3'd1, 32'h0, "R7");
        cyc(0, 0, 0, 3'd0, 32'h0, "R7");

        // Seeded random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic        t;
            logic        w;
            logic        r;
            logic [2:0]  a;
            logic [31:0] d;
            int unsigned op;
            t  = 1'($urandom % 2);
            op = $urandom % 16;
            w  = (op < 2);
            r  = (op == 2) || (op == 3);
            a  = 3'($urandom % 8);
            if (op == 0) a = 3'd0;
            if (op == 1) a = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'd2;
            if (r && ($urandom % 2 == 0)) a = 3'd0;
            d  = (32'($urandom % 9) << 9) | (32'($urandom) & 32'h8000_01FF);
            cyc(t, w, r, a, d, "R5");
        end

        summary();
        $finish;
    end

endmodule